// File: doc/BRIEF.md
# ADC result window comparator

This block watches a stream of finished converter results and raises a sticky flag whenever a result meets a window condition set by two programmable limits: an upper bound (the "above" limit) and a lower bound (the "below" limit). No software action is needed for each sample. Every result that arrives with its valid strobe is compared in the same cycle, and a hit sets the flag on that clock edge.

There is no mode bit. The way the two limits are ordered selects the sense of the flag. If the below limit is larger than the above limit, the flag reports results that fall strictly between them. If the below limit is less than or equal to the above limit, the flag reports results strictly above the above limit or strictly below the below limit. Each limit is written one byte at a time through a shared write port. A new limit is used only once both of its bytes have been written. Software polls the flag or takes the interrupt request, and clears the flag by writing zero.

Top module: `adc_window_monitor`

## Requirements
- R1: After reset the flag and interrupt are low, the above limit is all ones and the below limit is zero, so no result of any value sets the flag until the limits are changed.
- R2: When below limit > above limit, a valid result sets the flag exactly when above < result < below.
- R3: When below limit <= above limit, a valid result sets the flag exactly when result > above or result < below.
- R4: All comparisons are strict and unsigned. A result equal to either limit never sets the flag.
- R5: A result with `res_valid` low has no effect on the flag.
- R6: Once set, the flag stays high until it is cleared. Writing a one to the flag changes nothing.
- R7: A flag write (`flag_we` high) with `flag_wdata` = 0 clears the flag on the next edge.
- R8: If a clear and a setting result fall in the same cycle, the flag ends up set.
- R9: Limit writes use `lim_sel` 0 = above low byte, 1 = above high byte, 2 = below low byte, 3 = below high byte. The low byte is bits 7:0 and the high byte is the remaining upper bits. A limit's new value takes effect only after both of its bytes have been written, in either order. The value is then used from the next cycle on. Until then the previous value stays in force.
- R10: `win_irq` is high exactly when the flag is high.
- R11: Equal limits select outside sense, so with both limits at V any result other than V sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result strobe, one cycle per conversion |
| res_data | input | RES_W | Converter result, unsigned |
| lim_we | input | 1 | Limit byte write enable |
| lim_sel | input | 2 | Which limit byte is written (see R9) |
| lim_byte | input | 8 | Byte being written |
| flag_we | input | 1 | Software write to the flag |
| flag_wdata | input | 1 | Flag write value; 0 clears, 1 is ignored |
| win_flag | output | 1 | Sticky window flag |
| win_irq | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle: a software clear of the flag and a matching result that sets it. The bench drives both in one cycle, with the flag already high and again with it low. It expects the flag to read high afterwards, and only a later clear with no result present brings it low. A second overlap is a limit commit and a result in the same cycle. Here the result must be judged against the old limits, so the reference model updates its limits only after it has computed the expected flag for that cycle.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;

  localparam int BYTE_W = 8;

  // byte-lane select for limit writes; bit 1 picks the limit, bit 0 the half
  typedef enum logic [1:0] {
    SEL_ABV_LO = 2'd0,
    SEL_ABV_HI = 2'd1,
    SEL_BLW_LO = 2'd2,
    SEL_BLW_HI = 2'd3
  } lim_sel_e;

endpackage

// File: rtl/adcwin_limit.sv
module adcwin_limit
  import adcwin_pkg::*;
#(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [W-1:0]      value,
  output logic              commit
);
  localparam int HI_W = W - BYTE_W;

  logic [BYTE_W-1:0] lo_stg;
  logic [HI_W-1:0]   hi_stg;
  logic              lo_seen, hi_seen;
  logic [W-1:0]      next_val;

  // both halves present once this write lands
  assign commit   = (wr_lo || wr_hi) && (wr_lo || lo_seen) && (wr_hi || hi_seen);
  assign next_val = {(wr_hi ? wbyte[HI_W-1:0] : hi_stg), (wr_lo ? wbyte : lo_stg)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_stg  <= '0;
      hi_stg  <= '0;
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
      value   <= RST_VAL;
    end else begin
      if (wr_lo) lo_stg <= wbyte;
      if (wr_hi) hi_stg <= wbyte[HI_W-1:0];
      if (commit) begin
        value   <= next_val;
        lo_seen <= 1'b0;
        hi_seen <= 1'b0;
      end else begin
        lo_seen <= lo_seen | wr_lo;
        hi_seen <= hi_seen | wr_hi;
      end
    end
  end

  // R9: the live limit moves only on a commit
  a_r9_hold_until_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(value));

  // R9: a single half-write never commits on its own
  a_r9_half_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_seen && !hi_seen && (wr_lo ^ wr_hi)) |-> !commit);

endmodule

// File: rtl/adcwin_cmp.sv
module adcwin_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] abv,
  input  logic [W-1:0] blw,
  output logic         inside_mode,
  output logic         hit
);
  function automatic logic win_hit(input logic [W-1:0] r,
                                   input logic [W-1:0] a,
                                   input logic [W-1:0] b);
    logic in_sense;
    in_sense = (b > a);
    if (in_sense) return (r > a) && (r < b);
    else          return (r > a) || (r < b);
  endfunction

  assign inside_mode = (blw > abv);
  assign hit         = win_hit(res, abv, blw);

endmodule

// File: rtl/adcwin_flag.sv
module adcwin_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  // R6: sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_evt) |=> flag);

  // R8: a set beats a clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R7: a lone clear drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag);

endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import adcwin_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             lim_we,
  input  logic [1:0]       lim_sel,
  input  logic [7:0]       lim_byte,
  input  logic             flag_we,
  input  logic             flag_wdata,
  output logic             win_flag,
  output logic             win_irq
);
  localparam int NLIM = 2;   // index 0 = above limit, 1 = below limit

  logic [RES_W-1:0] lim_val [NLIM];
  logic [NLIM-1:0]  lim_commit;
  logic             inside_mode;
  logic             hit;
  logic             match_evt;
  logic             clear_evt;
  lim_sel_e         sel_e;

  assign sel_e = lim_sel_e'(lim_sel);

  for (genvar i = 0; i < NLIM; i++) begin : g_lim
    localparam logic [RES_W-1:0] RV = (i == 0) ? {RES_W{1'b1}} : {RES_W{1'b0}};
    logic wr_lo_i, wr_hi_i;
    assign wr_lo_i = lim_we && (sel_e == lim_sel_e'({i[0], 1'b0}));
    assign wr_hi_i = lim_we && (sel_e == lim_sel_e'({i[0], 1'b1}));
    adcwin_limit #(.W(RES_W), .RST_VAL(RV)) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (wr_lo_i),
      .wr_hi  (wr_hi_i),
      .wbyte  (lim_byte),
      .value  (lim_val[i]),
      .commit (lim_commit[i])
    );
  end

  adcwin_cmp #(.W(RES_W)) u_cmp (
    .res         (res_data),
    .abv         (lim_val[0]),
    .blw         (lim_val[1]),
    .inside_mode (inside_mode),
    .hit         (hit)
  );

  assign match_evt = res_valid && hit;
  assign clear_evt = flag_we && !flag_wdata;

  adcwin_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (match_evt),
    .clr_evt (clear_evt),
    .flag    (win_flag)
  );

  assign win_irq = win_flag;

  // R4: a result sitting on either limit never matches
  a_r4_strict_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_data == lim_val[0] || res_data == lim_val[1])) |-> !match_evt);

  // R5: the flag cannot rise without a result strobe
  a_r5_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_flag && !res_valid) |=> !win_flag);

  // R2: in inside sense a match lies above the above limit
  a_r2_inside_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && inside_mode) |-> (res_data > lim_val[0]));

  // R10: interrupt tracks the flag
  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    win_irq == win_flag);

endmodule

// File: tb/adc_window_monitor_test.sv
module adc_window_monitor_test;
  localparam int RES_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             res_valid = 1'b0;
  logic [RES_W-1:0] res_data = '0;
  logic             lim_we = 1'b0;
  logic [1:0]       lim_sel = '0;
  logic [7:0]       lim_byte = '0;
  logic             flag_we = 1'b0;
  logic             flag_wdata = 1'b0;
  logic             win_flag, win_irq;

  always #5 clk = ~clk;

  adc_window_monitor #(.RES_W(RES_W)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [RES_W-1:0] m_abv, m_blw;
  logic [7:0]       st_lo [2];
  logic [7:0]       st_hi [2];
  bit               sn_lo [2];
  bit               sn_hi [2];
  bit               m_flag;

  bit    exp_q [$];
  string tag_q [$];

  function automatic bit ref_hit(logic [RES_W-1:0] r, logic [RES_W-1:0] a, logic [RES_W-1:0] b);
    if (b <= a) return !((r >= b) && (r <= a));   // outside sense
    return (a < r) && (r < b);                    // inside sense
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected flag after the edge
  task automatic step(bit v, int d, bit we, int sel, int b, bit fw, bit fd, string tag);
    int li;
    bit lo;
    @(negedge clk);
    res_valid = v; res_data = RES_W'(d);
    lim_we = we; lim_sel = 2'(sel); lim_byte = 8'(b);
    flag_we = fw; flag_wdata = fd;
    if (v && ref_hit(RES_W'(d), m_abv, m_blw)) m_flag = 1'b1;
    else if (fw && !fd)                        m_flag = 1'b0;
    if (we) begin
      li = sel / 2;
      lo = (sel % 2) == 0;
      if (lo) begin st_lo[li] = 8'(b); sn_lo[li] = 1'b1; end
      else    begin st_hi[li] = 8'(b); sn_hi[li] = 1'b1; end
      if (sn_lo[li] && sn_hi[li]) begin
        if (li == 0) m_abv = {st_hi[0], st_lo[0]};
        else         m_blw = {st_hi[1], st_lo[1]};
        sn_lo[li] = 1'b0; sn_hi[li] = 1'b0;
      end
    end
    exp_q.push_back(m_flag);
    tag_q.push_back(tag);
  endtask

  task automatic sample(int d, string tag);
    step(1, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic clr(string tag);
    step(0, 0, 0, 0, 0, 1, 0, tag);
  endtask
  task automatic wl(int sel, int b, string tag);
    step(0, 0, 1, sel, b, 0, 0, tag);
  endtask
  task automatic set_lims(int a, int b, string tag);
    wl(1, a >> 8, tag); wl(0, a & 255, tag);
    wl(2, b & 255, tag); wl(3, b >> 8, tag);
  endtask

  // monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " flag"}, int'(win_flag), int'(e));
        check({t, " R10 irq"}, int'(win_irq), int'(e));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_abv = '1; m_blw = '0; m_flag = 1'b0;
    for (int i = 0; i < 2; i++) begin
      st_lo[i] = '0; st_hi[i] = '0; sn_lo[i] = 1'b0; sn_hi[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 reset flag", int'(win_flag), 0);
    check("R1 reset irq", int'(win_irq), 0);

    // R1: reset limits never match
    sample(0, "R1 min");
    sample(16'hFFFF, "R1 max");
    sample(16'h1234, "R1 mid");

    // R9: half-written above limit is not used
    wl(0, 8'h05, "R9 half abv lo");
    sample(16'h0800, "R9 half no use");
    wl(1, 8'h00, "R9 abv hi commit");   // above = 5, below = 0 -> outside
    sample(16'h0800, "R9 committed use");
    clr("R7 clear");

    // R2 inside: above 100, below 200
    set_lims(100, 200, "R2 setup");
    sample(150, "R2 inside hit");
    clr("R7 clear after inside");
    sample(50, "R2 below window");
    sample(250, "R2 above window");
    sample(100, "R4 eq above");
    sample(200, "R4 eq below");
    sample(101, "R4 just inside");
    clr("R7 clear");
    sample(199, "R4 just inside top");

    // R6: sticky, write of one ignored
    step(0, 0, 0, 0, 0, 1, 1, "R6 write one");
    step(0, 0, 0, 0, 0, 0, 0, "R6 idle");
    sample(50, "R6 non-match keeps");
    // R8: clear with a hit, flag already high
    step(1, 150, 0, 0, 0, 1, 0, "R8 set wins high");
    clr("R7 clear");
    // R8: clear with a hit, flag low
    step(1, 150, 0, 0, 0, 1, 0, "R8 set wins low");
    clr("R7 clear");

    // R5: strobe low ignored
    step(0, 150, 0, 0, 0, 0, 0, "R5 no valid");
    step(0, 150, 0, 0, 0, 0, 0, "R5 no valid again");

    // R9: high half written alone keeps old above limit (would flip mode)
    wl(1, 8'h01, "R9 abv hi only");
    sample(150, "R9 old limit kept");
    clr("R7 clear");
    // commit with a sample in the same cycle: old limits judge it
    step(1, 150, 1, 0, 8'h64, 0, 0, "R9 commit same cycle");
    clr("R7 clear");
    sample(150, "R9 new limit outside");  // above 356, below 200 -> outside, 150 < 200
    clr("R7 clear");

    // R3 outside: above 200, below 100, low-first order for below
    set_lims(200, 100, "R3 setup");
    sample(250, "R3 high side");
    clr("R7 clear");
    sample(50, "R3 low side");
    clr("R7 clear");
    sample(150, "R3 middle");
    sample(200, "R4 outside eq above");
    sample(100, "R4 outside eq below");
    sample(0, "R3 zero");
    clr("R7 clear");

    // R11 equal limits
    set_lims(300, 300, "R11 setup");
    sample(300, "R11 equal value");
    sample(301, "R11 one above");
    clr("R7 clear");
    sample(299, "R11 one below");
    clr("R7 clear");
    sample(300, "R11 equal again");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule